// File: doc/BRIEF.md
# Programmable External Bus Strobe Timer

This block times the address strobe and write enable for one external memory region that runs in fixed-wait mode. A 16-bit setup register holds, among other fields, three cycle counts: the cycle in which the address strobe goes low, the cycle in which it goes high again, and the cycle in which the write enable goes high. All counts are measured in clock cycles from the start of an access. Every write to the register is screened for prohibited or misordered timing values. A bad value sets an error flag that stays set until reset.

A client issues a one-cycle request with direction, address and write data. The block latches these together with the current timing fields. It then walks a cycle counter and drives the active-low strobes, the held address and the write-data byte lanes. When the access is over it returns a one-cycle done pulse. While an access is running, or while the error flag is set, new requests are dropped. The bus-mode, page and DRAM bits are only stored and read back.

Top module: `strobe_timer_top`

## Requirements
- R1: After reset the setup register reads 16'hEB50 (address-strobe assert 1, negate 3, write-enable negate 29, 16-bit width). `busy` and `done` are low, `as_n` and `we_n` are high, and `cfg_err` is low.
- R2: A setup write with `cfg_we` high stores `cfg_wdata` and shows it on `cfg_q` from the next cycle. Bit 5 always reads 0. Without `cfg_we` the register holds its value.
- R3: The address strobe assert count sits in bits 7:6 and the negate count in bits 10:8. With the counter at 0 in the first cycle after the request edge, `as_n` is low exactly while the count is at least the assert value and below the negate value.
- R4: The write-enable negate count sits in bits 15:11. On a write, `we_n` is low while the count runs from 1 up to one less than that value. On a read, `we_n` stays high.
- R5: `done` is high for exactly one cycle, when the count equals the later negate point. For a read that point is the address-strobe negate. For a write it is the larger of the two negates. `busy` is high from count 0 through the done cycle.
- R6: The timing fields and the bus width are captured when a request is accepted. A setup write during an access does not change that access.
- R7: A setup write with address-strobe negate 0, negate not greater than assert, or write-enable negate below 3 sets `cfg_err` one cycle later. The flag stays set through later valid writes until reset.
- R8: A request is ignored while `busy` is high or `cfg_err` is set. Such a request starts no access and does not disturb a running one.
- R9: Bit 4 selects the bus width: 0 is 8-bit, 1 is 16-bit. During a write access `bus_lane_oe` is 2'b01 with the upper data byte zero at 8-bit width, or 2'b11 with the full word at 16-bit width. Outside write accesses it is 2'b00 and the data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Setup register write strobe |
| cfg_wdata | input | 16 | Setup register write value |
| cfg_q | output | 16 | Setup register contents |
| cfg_err | output | 1 | Sticky bad-setting flag |
| req | input | 1 | One-cycle access request |
| req_wr | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Access address |
| req_data | input | DATA_W | Write data |
| busy | output | 1 | Access in progress |
| as_n | output | 1 | Address strobe, active low |
| we_n | output | 1 | Write enable, active low |
| bus_addr | output | ADDR_W | Address held for the access |
| bus_data | output | DATA_W | Write data on enabled lanes, zero otherwise |
| bus_lane_oe | output | DATA_W/8 | Per-byte drive enable |
| done | output | 1 | One-cycle access-complete pulse |

## Verification
The request edge is edge 0, and the counter value k is visible in the half cycle after edge k. Each access therefore yields one expected output set per cycle, for k = 0 through the done cycle, plus one idle cycle after it. The driver queues these sets right after edge 0, and the monitor pops one per falling edge. Setup writes are read back, and `cfg_err` is checked one edge after the write. Refused requests are followed by queued idle cycles, so any spurious start shows up in the cycles right after it.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

  localparam int unsigned CFG_W = 16;
  localparam int unsigned ASA_W = 2;
  localparam int unsigned ASN_W = 3;
  localparam int unsigned WEN_W = 5;
  localparam int unsigned WEN_MIN = 3;

  // Field order is the register layout, MSB first.
  typedef struct packed {
    logic [WEN_W-1:0] we_neg;
    logic [ASN_W-1:0] as_neg;
    logic [ASA_W-1:0] as_ast;
    logic             ro_bit;
    logic             wide;
    logic             page_en;
    logic             clk_sel;
    logic             wait_sel;
    logic             dram_en;
  } strobe_cfg_t;

  function automatic logic cfg_is_bad(strobe_cfg_t c);
    logic neg_zero, misorder, we_short;
    neg_zero = (c.as_neg == '0);
    misorder = (c.as_neg <= {1'b0, c.as_ast});
    we_short = (c.we_neg < WEN_W'(WEN_MIN));
    return neg_zero | misorder | we_short;
  endfunction

endpackage

// File: rtl/strobe_rst_sync.sv
module strobe_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/strobe_cfg_reg.sv
module strobe_cfg_reg
  import strobe_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_VAL = 16'hEB50
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CFG_W-1:0]   wdata,
  output strobe_cfg_t        cfg_o,
  output logic               err_o
);

  strobe_cfg_t cfg_d, cfg_q, cand;
  logic        err_d, err_q;

  always_comb begin
    cand        = strobe_cfg_t'(wdata);
    cand.ro_bit = 1'b0;
    cfg_d       = cfg_q;
    err_d       = err_q;
    if (wr_en) begin
      cfg_d = cand;
      err_d = err_q | cfg_is_bad(cand);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= strobe_cfg_t'(RESET_VAL & ~16'h0020);
      err_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
  import strobe_pkg::*;
#(
  parameter int unsigned CNT_W = WEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  strobe_cfg_t      cfg,
  input  logic             wr_in,
  output logic             busy,
  output logic             as_n,
  output logic             we_n,
  output logic             done,
  output logic             wr_o,
  output logic             wide_o
);

  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             busy_d, busy_q;
  logic [CNT_W-1:0] ast_q, asn_q, wen_q, end_q;
  logic [CNT_W-1:0] ast_x, asn_x, wen_x, end_x;
  logic             wr_q, wide_q;
  logic             last;

  assign ast_x = CNT_W'(cfg.as_ast);
  assign asn_x = CNT_W'(cfg.as_neg);
  assign wen_x = CNT_W'(cfg.we_neg);
  assign end_x = (wr_in && (wen_x > asn_x)) ? wen_x : asn_x;

  assign last = busy_q && (cnt_q == end_q);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  // Snapshot registers, loaded only when an access is accepted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ast_q  <= '0;
      asn_q  <= '0;
      wen_q  <= '0;
      end_q  <= '0;
      wr_q   <= 1'b0;
      wide_q <= 1'b0;
    end else if (start) begin
      ast_q  <= ast_x;
      asn_q  <= asn_x;
      wen_q  <= wen_x;
      end_q  <= end_x;
      wr_q   <= wr_in;
      wide_q <= cfg.wide;
    end
  end

  assign as_n   = !(busy_q && (cnt_q >= ast_q) && (cnt_q < asn_q));
  assign we_n   = !(busy_q && wr_q && (cnt_q != '0) && (cnt_q < wen_q));
  assign done   = last;
  assign busy   = busy_q;
  assign wr_o   = wr_q;
  assign wide_o = wide_q;

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy);

  p_as_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> as_n);

  p_we_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !wr_q) |-> we_n);

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= end_q));

endmodule

// File: rtl/strobe_lanes.sv
module strobe_lanes #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 drive,
  input  logic                 wide,
  output logic [DATA_W-1:0]    data_o,
  output logic [DATA_W/8-1:0]  oe_o
);

  localparam int unsigned LANES = DATA_W / 8;

  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= wdata;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_on;
    if (g == 0) begin : g_base
      assign lane_on = drive;
    end else begin : g_upper
      assign lane_on = drive && wide;
    end
    assign oe_o[g]           = lane_on;
    assign data_o[g*8 +: 8]  = lane_on ? data_q[g*8 +: 8] : 8'h00;
  end

  if (LANES > 1) begin : g_chk
    p_upper_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wide |-> (oe_o[LANES-1:1] == '0));
  end

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |-> (data_o == '0));

endmodule

// File: rtl/strobe_timer_top.sv
module strobe_timer_top
  import strobe_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 24,
  parameter int unsigned       DATA_W    = 16,
  parameter logic [CFG_W-1:0]  RESET_CFG = 16'hEB50
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [CFG_W-1:0]     cfg_q,
  output logic                 cfg_err,
  input  logic                 req,
  input  logic                 req_wr,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_data,
  output logic                 busy,
  output logic                 as_n,
  output logic                 we_n,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [DATA_W-1:0]    bus_data,
  output logic [DATA_W/8-1:0]  bus_lane_oe,
  output logic                 done
);

  localparam int unsigned CNT_W = WEN_W;

  logic        rst_i;
  strobe_cfg_t cfg;
  logic        err;
  logic        start;
  logic        busy_i, wr_i, wide_i;
  logic [ADDR_W-1:0] addr_q;

  strobe_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i)
  );

  strobe_cfg_reg #(.RESET_VAL(RESET_CFG)) u_cfg (
    .clk   (clk),
    .rst_n (rst_i),
    .wr_en (cfg_we),
    .wdata (cfg_wdata),
    .cfg_o (cfg),
    .err_o (err)
  );

  assign start = req && !busy_i && !err;

  strobe_seq #(.CNT_W(CNT_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_i),
    .start  (start),
    .cfg    (cfg),
    .wr_in  (req_wr),
    .busy   (busy_i),
    .as_n   (as_n),
    .we_n   (we_n),
    .done   (done),
    .wr_o   (wr_i),
    .wide_o (wide_i)
  );

  strobe_lanes #(.DATA_W(DATA_W)) u_lanes (
    .clk    (clk),
    .rst_n  (rst_i),
    .load   (start),
    .wdata  (req_data),
    .drive  (busy_i && wr_i),
    .wide   (wide_i),
    .data_o (bus_data),
    .oe_o   (bus_lane_oe)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)     addr_q <= '0;
    else if (start) addr_q <= req_addr;
  end

  assign bus_addr = addr_q;
  assign busy     = busy_i;
  assign cfg_q    = cfg;
  assign cfg_err  = err;

  p_refuse_err_r8: assert property (@(posedge clk) disable iff (!rst_i)
    (err && !busy_i) |=> !busy_i);

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (busy_i && $past(busy_i) && !$past(done)) |-> $stable(addr_q));

endmodule

// File: tb/strobe_timer_top_test.sv
`timescale 1ns/100ps
module strobe_timer_top_test;

  typedef struct {
    logic        busy;
    logic        as_n;
    logic        we_n;
    logic        done;
    logic [1:0]  oe;
    logic [15:0] dat;
    logic [23:0] adr;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_q;
  logic        cfg_err;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic        busy, as_n, we_n, done;
  logic [23:0] bus_addr;
  logic [15:0] bus_data;
  logic [1:0]  bus_lane_oe;

  int checks = 0;
  int errors = 0;
  logic [15:0] model = 16'hEB50;
  item_t q[$];

  always #2.5 clk = ~clk;

  strobe_timer_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q), .cfg_err(cfg_err), .req(req), .req_wr(req_wr),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .as_n(as_n),
    .we_n(we_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_lane_oe(bus_lane_oe), .done(done)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: one expected item per falling edge while the queue holds any.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk({it.tag, " R5 busy"}, 32'(busy), 32'(it.busy));
      chk({it.tag, " R3 as_n"}, 32'(as_n), 32'(it.as_n));
      chk({it.tag, " R4 we_n"}, 32'(we_n), 32'(it.we_n));
      chk({it.tag, " R5 done"}, 32'(done), 32'(it.done));
      chk({it.tag, " R9 oe"},   32'(bus_lane_oe), 32'(it.oe));
      chk({it.tag, " R9 data"}, 32'(bus_data), 32'(it.dat));
      if (it.busy) chk({it.tag, " R6 addr"}, 32'(bus_addr), 32'(it.adr));
    end
  end

  function automatic item_t idle_item(string tag);
    item_t it;
    it.busy = 0; it.as_n = 1; it.we_n = 1; it.done = 0;
    it.oe = 2'b00; it.dat = '0; it.adr = '0; it.tag = tag;
    return it;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model = 16'hEB50;
  endtask

  task automatic cfg_write(logic [15:0] val, logic exp_err, string tag);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    model = val & ~16'h0020;
    chk({tag, " R2 readback"}, 32'(cfg_q), 32'(model));
    chk({tag, " R7 err"}, 32'(cfg_err), 32'(exp_err));
  endtask

  // Driver: issues one access and queues the per-cycle expectation.
  task automatic access(logic wr, logic [23:0] adr, logic [15:0] dat,
                        int poke_req, int poke_cfg, logic [15:0] poke_val,
                        string tag);
    int asa, asn, wen, endpt;
    logic bw;
    asa = int'(model[7:6]); asn = int'(model[10:8]); wen = int'(model[15:11]);
    bw  = model[4];
    endpt = (wr && wen > asn) ? wen : asn;
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_addr = adr; req_data = dat;
    @(posedge clk);
    for (int k = 0; k <= endpt + 1; k++) begin
      item_t it;
      it.busy = (k <= endpt);
      it.as_n = !(it.busy && k >= asa && k < asn);
      it.we_n = !(it.busy && wr && k >= 1 && k < wen);
      it.done = (k == endpt);
      it.oe   = (it.busy && wr) ? (bw ? 2'b11 : 2'b01) : 2'b00;
      it.dat  = (it.busy && wr) ? (bw ? dat : {8'h00, dat[7:0]}) : 16'h0000;
      it.adr  = adr;
      it.tag  = tag;
      q.push_back(it);
    end
    for (int k = 0; k <= endpt + 1; k++) begin
      @(negedge clk);
      req = 1'b0; cfg_we = 1'b0;
      if (k == poke_req) begin
        req = 1'b1; req_wr = ~wr; req_addr = ~adr; req_data = ~dat;
      end
      if (k == poke_cfg) begin
        cfg_we = 1'b1; cfg_wdata = poke_val;
      end
    end
    req = 1'b0; cfg_we = 1'b0;
    if (poke_cfg >= 0) model = poke_val & ~16'h0020;
  endtask

  task automatic refused_req(string tag);
    @(negedge clk);
    req = 1'b1; req_wr = 1'b1; req_addr = 24'h0000AA; req_data = 16'h55AA;
    @(posedge clk);
    for (int k = 0; k < 3; k++) q.push_back(idle_item(tag));
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    // R1: reset contents and idle outputs
    @(negedge clk);
    chk("R1 cfg", 32'(cfg_q), 32'h0000EB50);
    chk("R1 err", 32'(cfg_err), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 as_n", 32'(as_n), 1);
    chk("R1 we_n", 32'(we_n), 1);
    chk("R1 done", 32'(done), 0);

    // Default timing: read then long write (write-enable negate 29)
    access(1'b0, 24'h001234, 16'h0000, -1, -1, 16'h0, "T1 read R3");
    access(1'b1, 24'h00ABCD, 16'hBEEF, -1, -1, 16'h0, "T2 write R4");

    // Tightest legal values, 8-bit width, bit 5 written as 1 (R2)
    cfg_write(16'h1920, 1'b0, "T3");
    access(1'b1, 24'h000010, 16'hC3A5, -1, -1, 16'h0, "T3 write8 R9");
    access(1'b0, 24'h000011, 16'h0000, -1, -1, 16'h0, "T3 read R3");

    // Latest strobe window, write negate earlier than AS negate
    cfg_write(16'h2FD0, 1'b0, "T4");
    access(1'b1, 24'h7F0000, 16'h1357, -1, -1, 16'h0, "T4 write R5");

    // R6: setup write during an access leaves it unchanged
    access(1'b1, 24'h000555, 16'h2468, -1, 2, 16'h1900, "T5 R6 snapshot");
    chk("R6 new cfg", 32'(cfg_q), 32'h00001900);
    access(1'b0, 24'h000556, 16'h0000, -1, -1, 16'h0, "T5 R6 next");

    // R8: request while busy is dropped (mid-access and in done cycle)
    cfg_write(16'hEB50, 1'b0, "T6");
    access(1'b0, 24'h000777, 16'h0000, 1, -1, 16'h0, "T6 R8 busy");
    access(1'b0, 24'h000778, 16'h0000, 3, -1, 16'h0, "T6 R8 done cycle");
    for (int k = 0; k < 3; k++) q.push_back(idle_item("T6 R8 after"));
    repeat (4) @(negedge clk);

    // Boundary: negate one above assert is legal
    cfg_write(16'h1B80, 1'b0, "T7");
    access(1'b0, 24'h000100, 16'h0000, -1, -1, 16'h0, "T7 read R3");

    // R7: negate code zero
    cfg_write(16'h1810, 1'b1, "T8 R7 neg0");
    refused_req("T8 R8 err");
    cfg_write(16'hEB50, 1'b1, "T8 R7 sticky");
    refused_req("T8 R8 err sticky");
    do_reset();
    chk("R7 cleared", 32'(cfg_err), 0);
    chk("R1 cfg again", 32'(cfg_q), 32'h0000EB50);

    // R7: negate equal to assert
    cfg_write(16'h1BC0, 1'b1, "T9 R7 order");
    do_reset();
    // R7: write-enable negate below 3
    cfg_write(16'h1300, 1'b1, "T10 R7 wen");
    refused_req("T10 R8 err");
    do_reset();
    access(1'b1, 24'h000042, 16'h00FF, -1, -1, 16'h0, "T11 after reset R5");

    repeat (3) @(negedge clk);
    chk("R5 queue drained", 32'(q.size()), 0);
    finish_run();
  end

endmodule